// File: doc/BRIEF.md
# DMA Channel Bus Bandwidth Limiter

This block throttles one DMA channel so that it cannot hold the system bus indefinitely. The channel is granted a budget of active clocks during which it may use the bus; once that budget is spent, the limiter makes the channel give the bus back and then keeps it off the bus for a programmed number of idle clocks. After the idle window both budgets start over and the channel may request the bus again. Each channel in a system gets its own instance, so every channel keeps its own counts.

The active budget is spent only on clocks where the arbiter reports that this channel owns the bus and no higher-priority master is pushing it off. While the channel is preempted (by the other DMA channel, the processor or an external bus request) the spent count freezes and resumes when ownership returns. The idle window, by contrast, advances on every clock whatever the bus is doing. A release triggered by an exhausted budget is deferred until the channel signals the end of its current operand transfer, so a multi-cycle operand is never split.

Top module: `dma_bw_limiter`

## Requirements
- R1: After reset, `req_allowed` is 1 and `release_bus` is 0, with the spent active count at zero.
- R2: With the limiter enabled, the active budget is spent by one on each clock edge where `bus_owned` is 1 and `preempt` is 0; the channel stays in its active phase (`req_allowed`=1, `release_bus`=0) until the edge that spends the last unit of `active_cnt`.
- R3: On clocks where `preempt` is 1 or `bus_owned` is 0 during the active phase, the spent count holds; the budget still ends after exactly `active_cnt` counted clocks in total.
- R4: If `operand_end` is 0 on the edge that exhausts the budget, the limiter waits with `req_allowed`=0 and `release_bus`=0 until an edge where `operand_end` is 1 or `bus_owned` is 0; `release_bus` rises after that edge.
- R5: During the idle window `req_allowed` is 0 and `release_bus` is 1 for exactly `idle_cnt` clocks, independent of `bus_owned`, `preempt` and `operand_end`.
- R6: When the idle window ends, both counts restart from zero, `req_allowed` returns to 1, and the counts in force are the values present on `active_cnt` and `idle_cnt` at that time.
- R7: With `enable` at 0, `req_allowed` is 1 and `release_bus` is 0 in the same cycle, no release ever occurs, and on re-enabling the channel receives a full active budget.
- R8: A programmed count of 0 behaves as a count of 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | 1 turns limiting on; 0 makes the limiter transparent |
| active_cnt | input | CNT_W | Active budget in counted clocks |
| idle_cnt | input | CNT_W | Idle window length in clocks |
| bus_owned | input | 1 | Arbiter reports this channel is bus master |
| preempt | input | 1 | A higher-priority master is taking the bus |
| operand_end | input | 1 | Current clock completes the channel's operand transfer |
| req_allowed | output | 1 | Channel may request the bus |
| release_bus | output | 1 | Channel must stay off the bus |

## Verification
Every phase change is taken on a clock edge from the inputs sampled at that edge, so `req_allowed` and `release_bus` reflect a stimulus one edge after it is applied; the only same-cycle path is `enable`, which overrides both outputs combinationally. The bench applies each input set on a falling edge, lets one rising edge pass and reads the outputs on the following falling edge, so every check counts edges exactly: an active budget of N shows its release after the N-th counted edge and an idle window of M ends after the M-th edge. The `enable` override is read a nanosecond after the input change, before any edge.

// File: rtl/bwl_pkg.sv
package bwl_pkg;

    typedef enum logic [1:0] {
        PH_ACTIVE = 2'd0,
        PH_DRAIN  = 2'd1,
        PH_IDLE   = 2'd2
    } phase_e;

    typedef struct packed {
        phase_e phase;
    } ctrl_state_t;

endpackage

// File: rtl/bwl_span_counter.sv
module bwl_span_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] value
);

    localparam logic [W-1:0] STEP = W'(1);

    logic [W-1:0] value_d;
    logic [W-1:0] value_q;

    always_comb begin
        value_d = value_q;
        if (clr) begin
            value_d = '0;
        end else if (inc) begin
            value_d = value_q + STEP;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            value_q <= '0;
        end else begin
            value_q <= value_d;
        end
    end

    assign value = value_q;

    // R3: no clear and no count means the spent value is frozen
    a_r3_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !inc) |=> $stable(value_q));

    // R2: a counted clock advances the value by exactly one
    a_r2_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !clr) |=> (value_q == $past(value_q) + STEP));

endmodule

// File: rtl/bwl_phase_ctrl.sv
module bwl_phase_ctrl
    import bwl_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         enable,
    input  logic [W-1:0] active_cnt,
    input  logic [W-1:0] idle_cnt,
    input  logic         bus_owned,
    input  logic         preempt,
    input  logic         operand_end,
    input  logic [W-1:0] act_used,
    input  logic [W-1:0] idle_used,
    output logic         act_clr,
    output logic         act_inc,
    output logic         idle_clr,
    output logic         idle_inc,
    output logic         req_allowed,
    output logic         release_bus
);

    localparam logic [W:0] ONE_X = (W+1)'(1);

    ctrl_state_t st_d;
    ctrl_state_t st_q;

    logic [W:0] act_limit;
    logic [W:0] idle_limit;
    logic       act_hit;
    logic       idle_hit;
    logic       counting;

    // zero budgets are promoted to one
    assign act_limit  = (active_cnt == '0) ? ONE_X : {1'b0, active_cnt};
    assign idle_limit = (idle_cnt == '0)   ? ONE_X : {1'b0, idle_cnt};

    assign counting = enable && (st_q.phase == PH_ACTIVE) && bus_owned && !preempt;
    assign act_hit  = ({1'b0, act_used} + ONE_X) >= act_limit;
    assign idle_hit = ({1'b0, idle_used} + ONE_X) >= idle_limit;

    always_comb begin
        st_d     = st_q;
        act_clr  = 1'b0;
        act_inc  = 1'b0;
        idle_clr = 1'b0;
        idle_inc = 1'b0;
        if (!enable) begin
            st_d.phase = PH_ACTIVE;
            act_clr    = 1'b1;
            idle_clr   = 1'b1;
        end else begin
            unique case (st_q.phase)
                PH_ACTIVE: begin
                    if (counting) begin
                        act_inc = 1'b1;
                        if (act_hit) begin
                            idle_clr   = 1'b1;
                            st_d.phase = operand_end ? PH_IDLE : PH_DRAIN;
                        end
                    end
                end
                PH_DRAIN: begin
                    if (operand_end || !bus_owned) begin
                        idle_clr   = 1'b1;
                        st_d.phase = PH_IDLE;
                    end
                end
                PH_IDLE: begin
                    idle_inc = 1'b1;
                    if (idle_hit) begin
                        act_clr    = 1'b1;
                        idle_clr   = 1'b1;
                        st_d.phase = PH_ACTIVE;
                    end
                end
                default: begin
                    st_d.phase = PH_ACTIVE;
                    act_clr    = 1'b1;
                    idle_clr   = 1'b1;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.phase <= PH_ACTIVE;
        end else begin
            st_q <= st_d;
        end
    end

    assign req_allowed = !enable || (st_q.phase == PH_ACTIVE);
    assign release_bus = enable && (st_q.phase == PH_IDLE);

    // R4: an unfinished operand keeps the limiter waiting before release
    a_r4_wait_operand: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && st_q.phase == PH_DRAIN && !operand_end && bus_owned)
        |=> (st_q.phase == PH_DRAIN));

    // R5: the idle window is not cut short by anything but its own count
    a_r5_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && st_q.phase == PH_IDLE && !idle_hit) |=> (st_q.phase == PH_IDLE));

    // R3: no counted clock means no exit from the active phase
    a_r3_no_spend_no_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_ACTIVE && !counting) |=> (st_q.phase == PH_ACTIVE));

    // R7: disabling returns to a fresh active phase
    a_r7_disable_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable) |=> (st_q.phase == PH_ACTIVE && act_used == '0));

    // R6: leaving idle starts the active budget from zero
    a_r6_fresh_budget: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && st_q.phase == PH_IDLE && idle_hit) |=> (act_used == '0));

endmodule

// File: rtl/dma_bw_limiter.sv
module dma_bw_limiter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [CNT_W-1:0] active_cnt,
    input  logic [CNT_W-1:0] idle_cnt,
    input  logic             bus_owned,
    input  logic             preempt,
    input  logic             operand_end,
    output logic             req_allowed,
    output logic             release_bus
);

    logic [CNT_W-1:0] act_used;
    logic [CNT_W-1:0] idle_used;
    logic             act_clr;
    logic             act_inc;
    logic             idle_clr;
    logic             idle_inc;

    bwl_span_counter #(.W(CNT_W)) u_act_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (act_clr),
        .inc   (act_inc),
        .value (act_used)
    );

    bwl_span_counter #(.W(CNT_W)) u_idle_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (idle_clr),
        .inc   (idle_inc),
        .value (idle_used)
    );

    bwl_phase_ctrl #(.W(CNT_W)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (enable),
        .active_cnt  (active_cnt),
        .idle_cnt    (idle_cnt),
        .bus_owned   (bus_owned),
        .preempt     (preempt),
        .operand_end (operand_end),
        .act_used    (act_used),
        .idle_used   (idle_used),
        .act_clr     (act_clr),
        .act_inc     (act_inc),
        .idle_clr    (idle_clr),
        .idle_inc    (idle_inc),
        .req_allowed (req_allowed),
        .release_bus (release_bus)
    );

    // R1/R5: the two outputs never demand opposite things at once
    a_r5_outputs_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_allowed && release_bus));

endmodule

// File: tb/test_dma_bw_limiter.sv
`timescale 1ns/1ps
module test_dma_bw_limiter;

    localparam int CNT_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             enable = 1'b0;
    logic [CNT_W-1:0] active_cnt = 8'd4;
    logic [CNT_W-1:0] idle_cnt = 8'd3;
    logic             bus_owned = 1'b0;
    logic             preempt = 1'b0;
    logic             operand_end = 1'b1;
    logic             req_allowed;
    logic             release_bus;

    int nchk = 0;
    int nfail = 0;

    always #2.5 clk = ~clk;

    dma_bw_limiter #(.CNT_W(CNT_W)) i_dma_bw_limiter (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (enable),
        .active_cnt  (active_cnt),
        .idle_cnt    (idle_cnt),
        .bus_owned   (bus_owned),
        .preempt     (preempt),
        .operand_end (operand_end),
        .req_allowed (req_allowed),
        .release_bus (release_bus)
    );

    task automatic expect_out(input string tag, input logic exp_req, input logic exp_rel);
        nchk++;
        if (req_allowed !== exp_req || release_bus !== exp_rel) begin
            nfail++;
            $display("FAIL %s: req_allowed/release_bus actual=%b/%b expected=%b/%b",
                     tag, req_allowed, release_bus, exp_req, exp_rel);
        end
    endtask

    // drive at a falling edge, pass one rising edge, return at the next falling edge
    task automatic cyc(input logic own, input logic pre, input logic oe);
        bus_owned   = own;
        preempt     = pre;
        operand_end = oe;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic finish_idle(input string tag, input int n);
        for (int i = 0; i < n - 1; i++) begin
            cyc(1'b0, 1'b0, 1'b1);
            expect_out(tag, 1'b0, 1'b1);
        end
        cyc(1'b0, 1'b0, 1'b1);
        expect_out(tag, 1'b1, 1'b0);
    endtask

    task automatic t_reset;
        expect_out("R1 during reset", 1'b1, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        enable = 1'b1;
        @(negedge clk);
        expect_out("R1 after reset", 1'b1, 1'b0);
    endtask

    task automatic t_basic;
        for (int i = 0; i < 3; i++) cyc(1'b1, 1'b0, 1'b1);
        expect_out("R2 budget not yet spent", 1'b1, 1'b0);
        cyc(1'b1, 1'b0, 1'b1);
        expect_out("R2 release after 4 owned clocks", 1'b0, 1'b1);
        finish_idle("R5 idle window 3 clocks", 3);
    endtask

    task automatic t_preempt;
        cyc(1'b1, 1'b0, 1'b1);
        cyc(1'b1, 1'b0, 1'b1);
        for (int i = 0; i < 3; i++) cyc(1'b1, 1'b1, 1'b1);
        for (int i = 0; i < 2; i++) cyc(1'b0, 1'b0, 1'b1);
        expect_out("R3 frozen across preemption", 1'b1, 1'b0);
        cyc(1'b1, 1'b0, 1'b1);
        expect_out("R3 resumed, one unit left", 1'b1, 1'b0);
        cyc(1'b1, 1'b0, 1'b1);
        expect_out("R3 release after 4 counted clocks", 1'b0, 1'b1);
        finish_idle("R3 idle after preempted budget", 3);
    endtask

    task automatic t_drain;
        for (int i = 0; i < 4; i++) cyc(1'b1, 1'b0, 1'b0);
        expect_out("R4 exhausted but operand open", 1'b0, 1'b0);
        cyc(1'b1, 1'b0, 1'b0);
        cyc(1'b1, 1'b0, 1'b0);
        expect_out("R4 still waiting for operand end", 1'b0, 1'b0);
        cyc(1'b1, 1'b0, 1'b1);
        expect_out("R4 release after operand end", 1'b0, 1'b1);
        // R5: bus activity during idle has no effect
        cyc(1'b1, 1'b1, 1'b0);
        expect_out("R5 idle ignores bus activity", 1'b0, 1'b1);
        cyc(1'b1, 1'b0, 1'b1);
        expect_out("R5 idle ignores ownership", 1'b0, 1'b1);
        cyc(1'b0, 1'b1, 1'b0);
        expect_out("R5 idle ends after 3 clocks", 1'b1, 1'b0);
        // R4: losing the bus also closes the wait
        active_cnt = 8'd1;
        idle_cnt   = 8'd1;
        cyc(1'b1, 1'b0, 1'b0);
        expect_out("R4 one-unit budget, operand open", 1'b0, 1'b0);
        cyc(1'b0, 1'b0, 1'b0);
        expect_out("R4 release on bus loss", 1'b0, 1'b1);
        cyc(1'b0, 1'b0, 1'b0);
        expect_out("R6 one-clock idle", 1'b1, 1'b0);
    endtask

    task automatic t_reprogram;
        active_cnt = 8'd2;
        idle_cnt   = 8'd3;
        cyc(1'b1, 1'b0, 1'b1);
        expect_out("R6 new budget of 2, first clock", 1'b1, 1'b0);
        cyc(1'b1, 1'b0, 1'b1);
        expect_out("R6 new budget of 2 spent", 1'b0, 1'b1);
        finish_idle("R6 idle with new window", 3);
        active_cnt = 8'd4;
    endtask

    task automatic t_disable;
        for (int i = 0; i < 4; i++) cyc(1'b1, 1'b0, 1'b1);
        expect_out("R7 entered idle", 1'b0, 1'b1);
        enable = 1'b0;
        #1;
        expect_out("R7 disable overrides at once", 1'b1, 1'b0);
        for (int i = 0; i < 10; i++) begin
            cyc(1'b1, 1'b0, 1'b1);
            expect_out("R7 no release while disabled", 1'b1, 1'b0);
        end
        enable = 1'b1;
        for (int i = 0; i < 3; i++) cyc(1'b1, 1'b0, 1'b1);
        expect_out("R7 full budget after re-enable", 1'b1, 1'b0);
        cyc(1'b1, 1'b0, 1'b1);
        expect_out("R7 release after full budget", 1'b0, 1'b1);
        finish_idle("R7 idle after re-enable", 3);
    endtask

    task automatic t_zero;
        active_cnt = 8'd0;
        idle_cnt   = 8'd0;
        cyc(1'b0, 1'b0, 1'b1);
        expect_out("R8 zero budget waits for ownership", 1'b1, 1'b0);
        cyc(1'b1, 1'b0, 1'b1);
        expect_out("R8 zero budget acts as one", 1'b0, 1'b1);
        cyc(1'b1, 1'b0, 1'b1);
        expect_out("R8 zero idle acts as one", 1'b1, 1'b0);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_basic();
        t_preempt();
        t_drain();
        t_reprogram();
        t_disable();
        t_zero();
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        nchk++;
        nfail++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

endmodule